// File: doc/BRIEF.md
# GF(2^89) Quadratic Equation Solver

The block solves z^2 + z = a for an element a of the binary field GF(2^89). The field is built on the trinomial u^89 + u^38 + 1, and bit i of a vector holds the coefficient of u^i. A point-halving datapath uses it as a helper. The caller drives an 89-bit operand and a one-cycle start pulse. A fixed number of clock edges later the block pulses done and holds one root together with two flags. The flags say whether a root exists.

Whenever a has a root, the roots come as a pair z and z+1, and the two differ only in bit 0. The block always returns the member of the pair with bit 0 clear. Internally it repeatedly raises a running power of a to the fourth and adds each result into an accumulator. The fourth power is taken with a sparse XOR network that is specific to the trinomial. A root exists exactly when the absolute trace of a is zero. For this trinomial the trace equals the XOR of bits 0 and 51 of a.

Top module: `gf_quad_solver`

## Requirements
- R1: After synchronous reset, z is all zero and valid, noSol and done are all 0.
- R2: When the trace of a is 0, the returned z satisfies z*z + z = a in GF(2^89), with reduction by u^89 + u^38 + 1.
- R3: Written per coefficient, that solution obeys the following rules. For an even position 2n, a[2n] is z[2n] ^ z[n], XORed further with z[n+70] when n is 0 to 18, with z[n+51] when n is 19 to 37, and with nothing more when n is 38 to 44. For an odd position 2n+1, a[2n+1] is z[2n+1] ^ z[n+45], XORed further with z[n+26] when n is 19 to 43.
- R4: When done pulses, noSol equals a[0] ^ a[51] and valid is its complement, so the two flags are never both high.
- R5: Bit 0 of z is always 0, which selects one root of the pair.
- R6: done is high for exactly one cycle, 45 rising edges after the edge that accepts start. z, valid and noSol take their new values on that same edge.
- R7: A start pulse that arrives while a solve is in progress is ignored. Neither the result nor the timing of the current solve changes.
- R8: The operand a is sampled only on the edge that accepts start. Later changes to a have no effect on the result.
- R9: Between done pulses, z, valid and noSol hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a solve on the operand a; accepted only when idle |
| a | input | 89 | Right-hand side, bit i is the coefficient of u^i |
| z | output | 89 | Returned root, bit 0 always 0 |
| valid | output | 1 | Held high when the last operand had a root |
| noSol | output | 1 | Held high when the last operand had no root (trace 1) |
| done | output | 1 | One-cycle pulse when a result is presented |

## Verification
The bench uses its own shift-and-add field multiplier and its own trace computation. With these it confirms that each root squares back onto the operand, and that the flags follow the trace. Under test are the operands 0 and 1, lone basis bits that include the two trace taps, their sum, and random values forced to each trace. A solver with a wrong reduction tap or squaring map returns a z that fails the check, and a wrong trace tap raises the flag for the wrong operands. A design that kept the other root leaves bit 0 set. A design that accepted a second start, or read a after the start edge, returns the root of the wrong operand or finishes late. A design that lets the outputs drift between results fails the hold check.

// File: rtl/qs_pkg.sv
package qs_pkg;
  localparam int FIELD_W = 89;
  localparam int TAP_K   = 38;

  typedef struct packed {
    logic load;
    logic step;
    logic finish;
  } qsCtrl_t;
endpackage

// File: rtl/qs_ctrl.sv
module qs_ctrl
  import qs_pkg::*;
#(
  parameter int ITER = 44
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    start,
  output qsCtrl_t strobe
);
  localparam int CW = $clog2(ITER + 1);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIN} state_t;
  state_t state;
  logic [CW-1:0] cnt;

  always_comb begin
    strobe.load   = (state == S_IDLE) && start;
    strobe.step   = (state == S_RUN);
    strobe.finish = (state == S_FIN);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          state <= S_RUN;
          cnt   <= '0;
        end
        S_RUN: begin
          if (cnt == CW'(ITER - 1)) state <= S_FIN;
          cnt <= cnt + 1'b1;
        end
        S_FIN:   state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/qs_datapath.sv
module qs_datapath
  import qs_pkg::*;
#(
  parameter int W = FIELD_W,
  parameter int K = TAP_K
) (
  input  logic         clk,
  input  logic         rst,
  input  qsCtrl_t      strobe,
  input  logic [W-1:0] a,
  output logic [W-1:0] z,
  output logic         valid,
  output logic         noSol,
  output logic         done
);
  // Squaring in the trinomial basis: bit i moves to 2i, folded back once or twice.
  function automatic logic [W-1:0] sqr(input logic [W-1:0] x);
    logic [W-1:0] r;
    int j;
    r = '0;
    for (int i = 0; i < W; i++) begin
      if (2 * i < W) begin
        r[2*i] = r[2*i] ^ x[i];
      end else begin
        j = 2 * i - W;
        r[j] = r[j] ^ x[i];
        if (K + j < W) begin
          r[K+j] = r[K+j] ^ x[i];
        end else begin
          r[K+j-W]   = r[K+j-W] ^ x[i];
          r[2*K+j-W] = r[2*K+j-W] ^ x[i];
        end
      end
    end
    return r;
  endfunction

  logic [W-1:0] pw, acc, pw4, zReg;
  logic         trBit, validReg, noSolReg, doneReg;

  always_comb pw4 = sqr(sqr(pw));

  always_ff @(posedge clk) begin
    if (rst) begin
      pw       <= '0;
      acc      <= '0;
      trBit    <= 1'b0;
      zReg     <= '0;
      validReg <= 1'b0;
      noSolReg <= 1'b0;
      doneReg  <= 1'b0;
    end else begin
      doneReg <= 1'b0;
      if (strobe.load) begin
        pw    <= a;
        acc   <= a;
        trBit <= a[0] ^ a[W-K];
      end
      if (strobe.step) begin
        pw  <= pw4;
        acc <= acc ^ pw4;
      end
      if (strobe.finish) begin
        zReg     <= {acc[W-1:1], 1'b0};
        noSolReg <= trBit;
        validReg <= ~trBit;
        doneReg  <= 1'b1;
      end
    end
  end

  assign z     = zReg;
  assign valid = validReg;
  assign noSol = noSolReg;
  assign done  = doneReg;
endmodule

// File: rtl/gf_quad_solver.sv
module gf_quad_solver
  import qs_pkg::*;
#(
  parameter int W = FIELD_W,
  parameter int K = TAP_K
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] a,
  output logic [W-1:0] z,
  output logic         valid,
  output logic         noSol,
  output logic         done
);
  localparam int ITER = (W - 1) / 2;

  qsCtrl_t strobe;

  qs_ctrl #(.ITER(ITER)) ctrl (
    .clk(clk), .rst(rst), .start(start), .strobe(strobe)
  );

  qs_datapath #(.W(W), .K(K)) dp (
    .clk(clk), .rst(rst), .strobe(strobe), .a(a),
    .z(z), .valid(valid), .noSol(noSol), .done(done)
  );
endmodule

// File: rtl/qs_checker.sv
module qs_checker #(
  parameter int W = 89
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] z,
  input logic         valid,
  input logic         noSol,
  input logic         done
);
  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R5
  root_pick_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (z[0] == 1'b0));

  // R4
  flag_excl_chk: assert property (@(posedge clk) disable iff (rst)
    valid |-> !noSol);

  // R4
  flag_set_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (valid != noSol));

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(z) && $stable(valid) && $stable(noSol)));
endmodule

bind gf_quad_solver qs_checker #(.W(W)) chk (
  .clk(clk), .rst(rst), .z(z), .valid(valid), .noSol(noSol), .done(done)
);

// File: tb/gf_quad_solver_test.sv
module gf_quad_solver_test;
  localparam int W   = 89;
  localparam int K   = 38;
  localparam int LAT = (W + 1) / 2;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [W-1:0] aIn = '0;
  logic [W-1:0] z;
  logic         valid, noSol, done;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  gf_quad_solver #(.W(W), .K(K)) uut (
    .clk(clk), .rst(rst), .start(start), .a(aIn),
    .z(z), .valid(valid), .noSol(noSol), .done(done)
  );

  function automatic logic [W-1:0] xtime(input logic [W-1:0] x);
    logic [W-1:0] r;
    r = x << 1;
    if (x[W-1]) r = r ^ (W'(1) | (W'(1) << K));
    return r;
  endfunction

  function automatic logic [W-1:0] gfMul(input logic [W-1:0] x, input logic [W-1:0] y);
    logic [W-1:0] r;
    r = '0;
    for (int i = W - 1; i >= 0; i--) begin
      r = xtime(r);
      if (y[i]) r = r ^ x;
    end
    return r;
  endfunction

  function automatic logic [W-1:0] traceOf(input logic [W-1:0] x);
    logic [W-1:0] s, t;
    s = x;
    t = x;
    for (int k = 1; k < W; k++) begin
      s = gfMul(s, s);
      t = t ^ s;
    end
    return t;
  endfunction

  function automatic logic [W-1:0] rnd();
    return W'({$urandom, $urandom, $urandom});
  endfunction

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act,
                     input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Issue start with operand x, wait for done, check latency and the result.
  task automatic solveCheck(input logic [W-1:0] x);
    int edges;
    logic [W-1:0] tr;
    bit expNo;
    @(negedge clk);
    start = 1'b1;
    aIn   = x;
    @(negedge clk);
    start = 1'b0;
    edges = 0;
    while (!done && edges < 100) begin
      @(negedge clk);
      edges++;
    end
    chk(edges == LAT, "R6 latency", W'(edges), W'(LAT));
    tr    = traceOf(x);
    expNo = tr[0];
    chk(tr[W-1:1] == '0, "R4 bench trace sanity", tr, W'(tr[0]));
    chk(noSol == expNo, "R4 noSol", W'(noSol), W'(expNo));
    chk(valid == !expNo, "R4 valid", W'(valid), W'(!expNo));
    chk(z[0] == 1'b0, "R5 root bit0", W'(z[0]), '0);
    if (!expNo) chk((gfMul(z, z) ^ z) == x, "R2 z^2+z", gfMul(z, z) ^ z, x);
    @(negedge clk);
    chk(done == 1'b0, "R6 single pulse", W'(done), '0);
  endtask

  task automatic testReset();
    chk(z == '0, "R1 z", z, '0);
    chk({valid, noSol, done} == 3'b000, "R1 flags", W'({valid, noSol, done}), '0);
  endtask

  task automatic testSpecial();
    logic [W-1:0] x;
    solveCheck('0);
    chk(z == '0 && valid, "R2 zero operand", z, '0);
    solveCheck(W'(1));
    chk(noSol == 1'b1, "R4 one has no root", W'(noSol), W'(1));
    x = '0; x[W-K] = 1'b1;
    solveCheck(x);
    chk(noSol == 1'b1, "R4 tap bit alone", W'(noSol), W'(1));
    x[0] = 1'b1;
    solveCheck(x);
    chk(valid == 1'b1, "R4 both taps", W'(valid), W'(1));
    for (int i = 1; i < W; i += 11) solveCheck(W'(1) << i);
  endtask

  task automatic testRandom();
    logic [W-1:0] x;
    for (int i = 0; i < 12; i++) begin
      x = rnd();
      x[0] = x[W-K] ^ (i % 2 == 1);
      solveCheck(x);
    end
  endtask

  task automatic testCoeff();
    logic [W-1:0] x, e;
    x = rnd();
    x[0] = x[W-K];
    solveCheck(x);
    e = '0;
    for (int n = 0; n <= 44; n++) begin
      e[2*n] = z[2*n] ^ z[n];
      if (n <= 18) e[2*n] = e[2*n] ^ z[n+70];
      else if (n <= 37) e[2*n] = e[2*n] ^ z[n+51];
    end
    for (int n = 0; n <= 43; n++) begin
      e[2*n+1] = z[2*n+1] ^ z[n+45];
      if (n >= 19) e[2*n+1] = e[2*n+1] ^ z[n+26];
    end
    chk(e == x, "R3 coefficient rules", e, x);
  endtask

  task automatic testBusy();
    logic [W-1:0] x1, x2;
    int edges;
    x1 = rnd(); x1[0] = x1[W-K];
    x2 = rnd(); x2[0] = ~x2[W-K];
    @(negedge clk);
    start = 1'b1;
    aIn   = x1;
    @(negedge clk);
    start = 1'b0;
    aIn   = x2;
    edges = 0;
    while (!done && edges < 100) begin
      @(negedge clk);
      edges++;
      if (edges == 10) start = 1'b1;
      if (edges == 11) begin
        start = 1'b0;
        aIn   = rnd();
      end
    end
    chk(edges == LAT, "R7 latency unchanged", W'(edges), W'(LAT));
    chk(valid == 1'b1, "R7 second start ignored", W'(valid), W'(1));
    chk((gfMul(z, z) ^ z) == x1, "R8 operand sampled at start", gfMul(z, z) ^ z, x1);
  endtask

  task automatic testHold();
    logic [W-1:0] zHeld;
    logic vHeld, nHeld;
    solveCheck(W'(1) << 3);
    zHeld = z; vHeld = valid; nHeld = noSol;
    for (int i = 0; i < 20; i++) begin
      aIn = rnd();
      @(negedge clk);
    end
    chk(z == zHeld, "R9 z held", z, zHeld);
    chk(valid == vHeld && noSol == nHeld && !done, "R9 flags held",
        W'({valid, noSol, done}), W'({vHeld, nHeld, 1'b0}));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rst = 1'b0;
    @(negedge clk);
    testSpecial();
    testRandom();
    testCoeff();
    testBusy();
    testHold();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule